// File: doc/BRIEF.md
# Strip-Based Transpose Block Buffer

This block reorganises one square tile of 8-bit samples so that an external set of edge filters can work on it twice, once for each direction. A coding unit arrives padded by four samples on each axis (8 to 12, 16 to 20, 32 to 36, 64 to 68). Because of the padding, the seam to the following unit falls inside the tile and no column has to be carried over to the next tile. The tile is written row by row into a raster buffer. It is then cut into strips four samples wide and streamed, one four-sample group per beat, to four parallel filter lanes. The filtered strips come back and are written transposed into a block buffer.

For the second direction, a select path reads the block buffer strip by strip and sends it out again to the filter lanes. The strips returned from that pass are transposed back into raster order and offered on a read port. The luma tile of each frame goes through first, then the two chroma tiles of the same size. A one-cycle pulse marks the end of the third tile.

Top module: `strip_transpose_buf`

## Requirements
- R1: The mode input sets the tile side when the first luma word is taken: 00 gives 12, 01 gives 20, 10 gives 36, 11 gives 68. Each pass then has side/4 strips of side beats each.
- R2: A tile is loaded as side*side/4 words in raster order, row by row. Lane k (bits 8k+7:8k) of word j of row r is the sample at row r, column 4j+k. The write port is ready only while a tile is being loaded.
- R3: In the first pass, beat b of strip s carries the samples of row b at columns 4s..4s+3, lane k holding column 4s+k, with the pass flag low. Data stays stable while the beat waits for ready.
- R4: In the second pass, beat b of strip s carries in lane k the first-pass return for row 4s+k, column b, with the pass flag high.
- R5: No second-pass beat is offered until every first-pass beat of the tile has come back.
- R6: The read port returns the second-pass results in raster order. Lane k of word j of row r is the second-pass return for row r, column 4j+k.
- R7: The tiles of a frame are read out tagged 0 (luma), 1 and 2 (chroma), all with the luma side. Mode changes after the first luma word are ignored.
- R8: The done output pulses for exactly one cycle, in the cycle after the last read handshake of tile 2.
- R9: After reset the write port is ready, and the strip-out valid, read valid and done outputs are low.
- R10: The strip-out last flag is high exactly on beat side-1 of every strip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Tile side select |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word accepted |
| wr_data | input | 32 | Four raster-order samples |
| so_valid | output | 1 | Strip beat valid to filter lanes |
| so_ready | input | 1 | Filter lanes accept beat |
| so_data | output | 32 | Four lane samples of the beat |
| so_pass | output | 1 | 0 first pass, 1 second pass |
| so_last | output | 1 | Final beat of the strip |
| si_valid | input | 1 | Filtered beat returned |
| si_ready | output | 1 | Returned beat accepted |
| si_data | input | 32 | Four filtered lane samples |
| rd_valid | output | 1 | Output word valid |
| rd_ready | input | 1 | Output word taken |
| rd_data | output | 32 | Four raster-order output samples |
| rd_comp | output | 2 | Tile tag: 0 luma, 1 and 2 chroma |
| done | output | 1 | End-of-frame pulse |

## Verification
The assertions assume that the filter lanes return exactly one beat for each beat sent, in the order sent, and only while a pass is running. They do not assume any fixed latency for the returns. The testbench meets this with a combinational model of the lanes. That model derives its return valid from the strip-out valid, gates both handshakes with one shared enable, and alters the samples by a different known function in each pass. The enable is pulsed to apply backpressure, so the hold and ordering checks see stalled beats without any return being lost or duplicated.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic [1:0] {PH_LOAD, PH_FWD, PH_REV, PH_DRAIN} phase_e;

  // padded tile side for each mode code
  function automatic logic [7:0] tile_side(input logic [1:0] m);
    case (m)
      2'd0:    tile_side = 8'd12;
      2'd1:    tile_side = 8'd20;
      2'd2:    tile_side = 8'd36;
      default: tile_side = 8'd68;
    endcase
  endfunction
endpackage

// File: rtl/strip_ctr.sv
module strip_ctr #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW-1:0] in_lim,
  input  logic [CW-1:0] out_lim,
  output logic [CW-1:0] inner,
  output logic [CW-1:0] outer,
  output logic          last
);
  logic in_wrap;
  assign in_wrap = (inner == in_lim - 1'b1);
  assign last    = in_wrap && (outer == out_lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inner <= '0;
      outer <= '0;
    end else if (adv) begin
      if (in_wrap) begin
        inner <= '0;
        outer <= last ? '0 : outer + 1'b1;
      end else begin
        inner <= inner + 1'b1;
      end
    end
  end

  assert_inner_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inner < in_lim);
endmodule

// File: rtl/strip_buf.sv
module strip_buf #(
  parameter int NMAX = 68,
  parameter int SW   = 8
) (
  input  logic                                  clk,
  input  logic [$clog2(NMAX*(NMAX/4))-1:0]      rd_idx,
  output logic [4*SW-1:0]                       rd_word,
  input  logic                                  wen,
  input  logic [$clog2(NMAX*(NMAX/4))-1:0]      widx,
  input  logic [4*SW-1:0]                       wdata,
  input  logic                                  sen,
  input  logic [$clog2(NMAX+1)-1:0]             srow,
  input  logic [$clog2(NMAX+1)-1:0]             scol,
  input  logic [4*SW-1:0]                       sdata
);
  localparam int WPR   = NMAX / 4;
  localparam int DEPTH = NMAX * WPR;
  localparam int IW    = $clog2(DEPTH);

  logic [4*SW-1:0] mem [DEPTH];
  logic [IW-1:0]   s_idx [4];
  logic [1:0]      s_lane;

  assign s_lane  = scol[1:0];
  assign rd_word = mem[rd_idx];

  // scatter: lane k of the beat lands in row srow+k, column scol
  always_comb begin
    for (int k = 0; k < 4; k++)
      s_idx[k] = (IW'(srow) + IW'(k)) * IW'(WPR) + IW'(scol >> 2);
  end

  always_ff @(posedge clk) begin
    if (wen) mem[widx] <= wdata;
    if (sen) begin
      for (int k = 0; k < 4; k++)
        mem[s_idx[k]][s_lane*SW +: SW] <= sdata[k*SW +: SW];
    end
  end
endmodule

// File: rtl/strip_transpose_buf.sv
module strip_transpose_buf #(
  parameter int NMAX = 68,
  parameter int SW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [4*SW-1:0] wr_data,
  output logic            so_valid,
  input  logic            so_ready,
  output logic [4*SW-1:0] so_data,
  output logic            so_pass,
  output logic            so_last,
  input  logic            si_valid,
  output logic            si_ready,
  input  logic [4*SW-1:0] si_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [4*SW-1:0] rd_data,
  output logic [1:0]      rd_comp,
  output logic            done
);
  import stb_pkg::*;

  localparam int WPR   = NMAX / 4;
  localparam int DEPTH = NMAX * WPR;
  localparam int IW    = $clog2(DEPTH);
  localparam int CW    = $clog2(NMAX + 1);

  phase_e        phase;
  logic [1:0]    comp;
  logic [CW-1:0] side_q, side, wpr;
  logic          out_done;
  logic [CW-1:0] a_in, a_out, o_in, o_out, i_in, i_out;
  logic          a_last, o_last, i_last;
  logic [4*SW-1:0] r_word, t_word;
  logic [IW-1:0] raster_idx, pass_idx, r_rd_idx;

  // named events
  logic in_pass, side_open, wr_fire, rd_fire, so_fire, si_fire;
  logic load_done, pass_done, tile_out, frame_end;

  assign in_pass   = (phase == PH_FWD) || (phase == PH_REV);
  assign side_open = (phase == PH_LOAD) && (comp == 2'd0) && (a_in == '0) && (a_out == '0);
  assign side      = side_open ? CW'(tile_side(mode)) : side_q;
  assign wpr       = side >> 2;

  assign wr_ready = (phase == PH_LOAD);
  assign rd_valid = (phase == PH_DRAIN);
  assign so_valid = in_pass && !out_done;
  assign si_ready = in_pass;
  assign so_pass  = (phase == PH_REV);
  assign so_last  = (o_in == side - 1'b1);
  assign rd_comp  = comp;

  assign wr_fire   = wr_valid && wr_ready;
  assign rd_fire   = rd_valid && rd_ready;
  assign so_fire   = so_valid && so_ready;
  assign si_fire   = si_valid && si_ready;
  assign load_done = wr_fire && a_last;
  assign pass_done = si_fire && i_last;
  assign tile_out  = rd_fire && a_last;
  assign frame_end = tile_out && (comp == 2'd2);

  // raster counter: outer = row, inner = word column
  strip_ctr #(.CW(CW)) u_raster (.clk(clk), .rst_n(rst_n), .adv(wr_fire || rd_fire),
    .in_lim(wpr), .out_lim(side), .inner(a_in), .outer(a_out), .last(a_last));
  // strip send counter: outer = strip, inner = beat
  strip_ctr #(.CW(CW)) u_send (.clk(clk), .rst_n(rst_n), .adv(so_fire),
    .in_lim(side), .out_lim(wpr), .inner(o_in), .outer(o_out), .last(o_last));
  // strip return counter
  strip_ctr #(.CW(CW)) u_ret (.clk(clk), .rst_n(rst_n), .adv(si_fire),
    .in_lim(side), .out_lim(wpr), .inner(i_in), .outer(i_out), .last(i_last));

  assign raster_idx = IW'(a_out) * IW'(WPR) + IW'(a_in);
  assign pass_idx   = IW'(o_in) * IW'(WPR) + IW'(o_out);
  assign r_rd_idx   = (phase == PH_DRAIN) ? raster_idx : pass_idx;

  // raster buffer: holds the input tile, later the transposed-back result
  strip_buf #(.NMAX(NMAX), .SW(SW)) u_rbuf (.clk(clk), .rd_idx(r_rd_idx), .rd_word(r_word),
    .wen(wr_fire), .widx(raster_idx), .wdata(wr_data),
    .sen(si_fire && phase == PH_REV), .srow({i_out[CW-3:0], 2'b00}), .scol(i_in),
    .sdata(si_data));
  // block buffer: first-pass strips stored transposed
  strip_buf #(.NMAX(NMAX), .SW(SW)) u_tbuf (.clk(clk), .rd_idx(pass_idx), .rd_word(t_word),
    .wen(1'b0), .widx('0), .wdata('0),
    .sen(si_fire && phase == PH_FWD), .srow({i_out[CW-3:0], 2'b00}), .scol(i_in),
    .sdata(si_data));

  // select path for the strip stream
  assign so_data = (phase == PH_FWD) ? r_word : t_word;
  assign rd_data = r_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_LOAD;
      comp     <= 2'd0;
      side_q   <= CW'(12);
      out_done <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= frame_end;
      if (side_open) side_q <= side;
      if (so_fire && o_last) out_done <= 1'b1;
      case (phase)
        PH_LOAD:  if (load_done) phase <= PH_FWD;
        PH_FWD:   if (pass_done) begin phase <= PH_REV;   out_done <= 1'b0; end
        PH_REV:   if (pass_done) begin phase <= PH_DRAIN; out_done <= 1'b0; end
        default:  if (tile_out) begin
                    phase <= PH_LOAD;
                    comp  <= (comp == 2'd2) ? 2'd0 : comp + 2'd1;
                  end
      endcase
    end
  end

  assert_beat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid && !so_ready |=> so_valid && $stable(so_data));
  assert_return_in_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    si_valid |-> si_ready);
  assert_second_after_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_pass) |-> $past(si_valid && si_ready));
  assert_side_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (comp != 2'd0) |=> $stable(side_q));
  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_valid && rd_ready && rd_comp == 2'd2));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_strip_transpose_buf.sv
`timescale 1ns/1ps
module tb_strip_transpose_buf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic wr_ready, so_valid, so_ready, so_pass, so_last, si_valid, si_ready;
  logic rd_valid, done;
  logic [31:0] so_data, si_data, rd_data;
  logic [1:0] rd_comp;
  logic f_en = 1'b1, bp_on = 1'b0;
  int bp_cnt = 0;
  int vecs = 0, errs = 0;
  bit finished = 1'b0;
  logic [7:0] img [0:67][0:67];
  int cur_side = 12, ep = 0, es = 0, eb = 0;

  always #2.5 clk = ~clk;

  strip_transpose_buf dut (.clk(clk), .rst_n(rst_n), .mode(mode), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .so_valid(so_valid), .so_ready(so_ready),
    .so_data(so_data), .so_pass(so_pass), .so_last(so_last), .si_valid(si_valid),
    .si_ready(si_ready), .si_data(si_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_comp(rd_comp), .done(done));

  // filter lane model: +1 per sample on the first pass, xor 5A on the second
  function automatic logic [31:0] lane_fn(logic [31:0] d, logic p);
    logic [31:0] o;
    for (int k = 0; k < 4; k++)
      o[k*8 +: 8] = p ? (d[k*8 +: 8] ^ 8'h5A) : (d[k*8 +: 8] + 8'd1);
    return o;
  endfunction

  assign si_valid = so_valid && f_en;
  assign so_ready = si_ready && f_en;
  assign si_data  = lane_fn(so_data, so_pass);

  always @(posedge clk) begin
    #1;
    bp_cnt++;
    f_en = !bp_on || (bp_cnt % 3 != 0);
  end

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pix(int seed, int comp, int r, int c);
    return 8'(seed + r*7 + c*13 + comp*29);
  endfunction

  // strip stream monitor (R3, R4, R5, R10)
  always @(negedge clk) begin
    logic [31:0] ex;
    if (rst_n && so_valid && so_ready) begin
      for (int k = 0; k < 4; k++)
        ex[k*8 +: 8] = (ep == 0) ? img[eb][4*es+k] : img[4*es+k][eb] + 8'd1;
      check(so_data == ex, (ep == 0) ? "R3 first-pass beat" : "R4 second-pass beat",
            so_data, ex);
      check(so_pass == ep[0], "R5 pass order", 32'(so_pass), 32'(ep));
      check(so_last == (eb == cur_side-1), "R10 last flag", 32'(so_last),
            32'(eb == cur_side-1));
      eb++;
      if (eb == cur_side) begin
        eb = 0; es++;
        if (es == cur_side/4) begin es = 0; ep++; end
      end
    end
  end

  task automatic do_tile(int seed, int comp, int side, bit swap, logic [1:0] alt);
    logic [31:0] ex;
    for (int r = 0; r < side; r++)
      for (int c = 0; c < side; c++) img[r][c] = pix(seed, comp, r, c);
    cur_side = side; ep = 0; es = 0; eb = 0;
    for (int r = 0; r < side; r++)
      for (int j = 0; j < side/4; j++) begin
        @(negedge clk);
        if (swap && (r != 0 || j != 0)) mode = alt;
        wr_valid = 1'b1;
        for (int k = 0; k < 4; k++) wr_data[k*8 +: 8] = img[r][4*j+k];
        while (!wr_ready) @(negedge clk);
      end
    @(negedge clk);
    wr_valid = 1'b0;
    for (int r = 0; r < side; r++)
      for (int j = 0; j < side/4; j++) begin
        if (r != 0 || j != 0) @(negedge clk);
        rd_ready = 1'b1;
        while (!rd_valid) @(negedge clk);
        for (int k = 0; k < 4; k++) ex[k*8 +: 8] = (img[r][4*j+k] + 8'd1) ^ 8'h5A;
        check(rd_data == ex, "R6 raster output", rd_data, ex);
        if (j == 0) check(rd_comp == comp[1:0], "R7 tile tag", 32'(rd_comp), 32'(comp));
      end
    @(negedge clk);
    rd_ready = 1'b0;
    check(done == (comp == 2), "R8 done after last read", 32'(done), 32'(comp == 2));
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic do_frame(logic [1:0] m, int seed, bit swap, logic [1:0] alt);
    int side;
    side = (m == 0) ? 12 : (m == 1) ? 20 : (m == 2) ? 36 : 68;
    mode = m;
    for (int c = 0; c < 3; c++) begin
      do_tile(seed, c, side, swap && c == 0, alt);
      check(wr_ready == 1'b1, "R2 write port ready for next tile", 32'(wr_ready), 32'd1);
    end
  endtask

  task automatic test_reset;
    check(wr_ready == 1'b1, "R9 reset wr_ready", 32'(wr_ready), 32'd1);
    check(so_valid == 1'b0, "R9 reset so_valid", 32'(so_valid), 32'd0);
    check(rd_valid == 1'b0, "R9 reset rd_valid", 32'(rd_valid), 32'd0);
    check(done == 1'b0, "R9 reset done", 32'(done), 32'd0);
  endtask

  task automatic test_small;  do_frame(2'd0, 3, 1'b0, 2'd0); endtask   // R1 side 12
  task automatic test_twenty; do_frame(2'd1, 41, 1'b0, 2'd0); endtask  // R1 side 20
  task automatic test_stall_swap;                                      // R7 mode ignored
    bp_on = 1'b1;
    do_frame(2'd2, 77, 1'b1, 2'd0);
    bp_on = 1'b0;
  endtask
  task automatic test_large;  do_frame(2'd3, 150, 1'b0, 2'd0); endtask // R1 side 68

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset;
    test_small;
    test_twenty;
    test_stall_swap;
    test_large;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule